// File: doc/BRIEF.md
# Block Memory Move Engine

This engine performs the byte-by-byte block copy used by the forward and backward block move instructions of a 16-bit accumulator processor. It receives a two-byte operand, the two index registers, the accumulator (a byte count minus one) and a direction select. It then copies bytes from `{source bank, X}` to `{destination bank, Y}` through a byte read port and a byte write port. Each port uses a request/acknowledge pair.

After every byte, both indexes step by one in the chosen direction, and the accumulator drops by one. The move ends when the accumulator wraps from 0x0000 to 0xFFFF, so A+1 bytes are copied in total. A cost counter adds two fast-cycle units for each byte.

An interrupt request can stop the copy between bytes. When that happens, a one-cycle rewind pulse tells the instruction sequencer to move the program counter back by 3, so the instruction is fetched again. The updated X, Y, A and data bank values stay on the outputs. Starting the engine again with those values finishes the copy.

Top module: `blkmove_engine`

## Requirements
- R1: Reset state. While reset is asserted and after it is released: `busy`, `rd_req`, `wr_req`, `done` and `rewind` are 0.
- R2: Start and addresses. On an accepted `start`, `dbank_out` is loaded with `operand[7:0]` (the first operand byte, the destination bank), and the source bank is loaded from `operand[15:8]`. The read address is `{source bank, X}` and the write address is `{dbank_out, Y}`.
- R3: Forward moves. With `fwd=1`, X and Y each increase by one after every byte is written.
- R4: Backward moves. With `fwd=0`, X and Y each decrease by one after every byte is written.
- R5: Narrow index mode. With `idx8=1`, only bits 7:0 of X and Y step, and they wrap within 8 bits. Bits 15:8 keep their start values.
- R6: Count and termination. A decreases by one per byte. The move ends after the byte written while A was 0x0000, leaving A=0xFFFF. A start value of N copies N+1 bytes.
- R7: Cost counter. `cycle_units` is cleared on start and increases by 2 for each byte written.
- R8: Transfer order. Each byte is read before it is written, and the written byte equals the byte read. The two requests are never high together, and there is never more than one outstanding transfer.
- R9: Completion pulse. `done` is high for exactly one cycle, in the cycle after the final write is acknowledged.
- R10: Pause. If `irq` is high when a non-final write is acknowledged, the engine goes idle and pulses `rewind` for one cycle, with the updated X, Y, A and bank values held. Restarting with those values completes the remaining bytes.
- R11: Busy lockout. A `start` while `busy` is high is ignored. Operand and register inputs have no effect until the move ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a move (when idle) |
| fwd | input | 1 | 1 = forward (increment), 0 = backward (decrement) |
| idx8 | input | 1 | 1 = 8-bit index registers |
| operand | input | 16 | [7:0] destination bank, [15:8] source bank |
| x_in | input | 16 | Source index start value |
| y_in | input | 16 | Destination index start value |
| a_in | input | 16 | Byte count minus one |
| irq | input | 1 | Pause request, sampled at each write acknowledge |
| rd_req | output | 1 | Read request |
| rd_addr | output | 24 | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 8 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 24 | Write address |
| wr_data | output | 8 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| x_out | output | 16 | Current X |
| y_out | output | 16 | Current Y |
| a_out | output | 16 | Current accumulator |
| dbank_out | output | 8 | Data bank register |
| cycle_units | output | 16 | Fast-cycle units spent in this run |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse at completion |
| rewind | output | 1 | One-cycle pulse: paused, PC must go back by 3 |

## Verification
Forward and backward copies with 16-bit indexes separate the two stepping directions. Narrow-index copies placed across an 8-bit boundary show whether the high byte is kept and the low byte wraps. A zero count proves a single byte is copied, and a larger count checks the wrap-based termination. A paused-and-resumed copy must give the same memory image and final registers as an uninterrupted one. A stray start in the middle of a move must change neither the addresses nor the final values.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_t;
endpackage

// File: rtl/blkmove_idx_step.sv
// Steps an index register by one; in narrow mode only the low part moves.
module blkmove_idx_step #(
  parameter int W     = 16,
  parameter int LOW_W = 8
) (
  input  logic [W-1:0] idx_i,
  input  logic         fwd_i,
  input  logic         narrow_i,
  output logic [W-1:0] idx_o
);
  logic [W-1:0]     full_step;
  logic [LOW_W-1:0] low_step;

  always_comb begin
    full_step = fwd_i ? idx_i + W'(1) : idx_i - W'(1);
    low_step  = fwd_i ? idx_i[LOW_W-1:0] + LOW_W'(1) : idx_i[LOW_W-1:0] - LOW_W'(1);
    if (narrow_i) idx_o = {idx_i[W-1:LOW_W], low_step};
    else          idx_o = full_step;
  end
endmodule

// File: rtl/blkmove_ctrl.sv
// Sequencer: one read, then one write, per byte.
module blkmove_ctrl
  import blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic irq,
  input  logic last,
  input  logic rd_ack,
  input  logic wr_ack,
  output logic load,
  output logic capture,
  output logic step,
  output logic rd_req,
  output logic wr_req,
  output logic busy,
  output logic done,
  output logic rewind
);
  mv_state_t st_q, st_d;
  logic      done_d, rewind_d;

  always_comb begin
    st_d     = st_q;
    done_d   = 1'b0;
    rewind_d = 1'b0;
    unique case (st_q)
      MV_IDLE:  if (start) st_d = MV_READ;
      MV_READ:  if (rd_ack) st_d = MV_WRITE;
      MV_WRITE: if (wr_ack) begin
        if (last) begin
          st_d   = MV_IDLE;
          done_d = 1'b1;
        end else if (irq) begin
          st_d     = MV_IDLE;
          rewind_d = 1'b1;
        end else begin
          st_d = MV_READ;
        end
      end
      default: st_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MV_IDLE;
      done   <= 1'b0;
      rewind <= 1'b0;
    end else begin
      st_q   <= st_d;
      done   <= done_d;
      rewind <= rewind_d;
    end
  end

  assign rd_req  = (st_q == MV_READ);
  assign wr_req  = (st_q == MV_WRITE);
  assign busy    = (st_q != MV_IDLE);
  assign load    = (st_q == MV_IDLE) && start;
  assign capture = rd_req && rd_ack;
  assign step    = wr_req && wr_ack;

  // R8: a write request only begins right after an acknowledged read
  p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_ack));
  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: after a pause the engine is idle
  p_pause_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |-> !busy);
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int IDX_W        = 16,
  parameter int NARROW_W     = 8,
  parameter int BANK_W       = 8,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 16,
  parameter int CYC_W        = 16,
  parameter int CYC_PER_BYTE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     fwd,
  input  logic                     idx8,
  input  logic [2*BANK_W-1:0]      operand,
  input  logic [IDX_W-1:0]         x_in,
  input  logic [IDX_W-1:0]         y_in,
  input  logic [CNT_W-1:0]         a_in,
  input  logic                     irq,
  output logic                     rd_req,
  output logic [BANK_W+IDX_W-1:0]  rd_addr,
  input  logic                     rd_ack,
  input  logic [DATA_W-1:0]        rd_data,
  output logic                     wr_req,
  output logic [BANK_W+IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_ack,
  output logic [IDX_W-1:0]         x_out,
  output logic [IDX_W-1:0]         y_out,
  output logic [CNT_W-1:0]         a_out,
  output logic [BANK_W-1:0]        dbank_out,
  output logic [CYC_W-1:0]         cycle_units,
  output logic                     busy,
  output logic                     done,
  output logic                     rewind
);
  localparam logic [CYC_W-1:0] CYC_INC = CYC_W'(CYC_PER_BYTE);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [IDX_W-1:0]  x_q, y_q, x_d, y_d, x_nx, y_nx;
  logic [CNT_W-1:0]  a_q, a_d;
  logic [BANK_W-1:0] dbank_q, dbank_d, sbank_q, sbank_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic              fwd_q, fwd_d, narrow_q, narrow_d;
  logic              load, capture, step, last;

  assign last = (a_q == '0);

  blkmove_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_ni), .start(start), .irq(irq), .last(last),
    .rd_ack(rd_ack), .wr_ack(wr_ack), .load(load), .capture(capture),
    .step(step), .rd_req(rd_req), .wr_req(wr_req), .busy(busy),
    .done(done), .rewind(rewind)
  );

  blkmove_idx_step #(.W(IDX_W), .LOW_W(NARROW_W)) u_step_x (
    .idx_i(x_q), .fwd_i(fwd_q), .narrow_i(narrow_q), .idx_o(x_nx));
  blkmove_idx_step #(.W(IDX_W), .LOW_W(NARROW_W)) u_step_y (
    .idx_i(y_q), .fwd_i(fwd_q), .narrow_i(narrow_q), .idx_o(y_nx));

  always_comb begin
    x_d = x_q; y_d = y_q; a_d = a_q;
    dbank_d = dbank_q; sbank_d = sbank_q;
    fwd_d = fwd_q; narrow_d = narrow_q;
    data_d = data_q; cyc_d = cyc_q;
    if (load) begin
      x_d      = x_in;
      y_d      = y_in;
      a_d      = a_in;
      dbank_d  = operand[BANK_W-1:0];
      sbank_d  = operand[2*BANK_W-1:BANK_W];
      fwd_d    = fwd;
      narrow_d = idx8;
      cyc_d    = '0;
    end
    if (capture) data_d = rd_data;
    if (step) begin
      x_d   = x_nx;
      y_d   = y_nx;
      a_d   = a_q - CNT_W'(1);
      cyc_d = cyc_q + CYC_INC;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; y_q <= '0; a_q <= '0;
      dbank_q <= '0; sbank_q <= '0;
      fwd_q <= 1'b0; narrow_q <= 1'b0;
      data_q <= '0; cyc_q <= '0;
    end else begin
      x_q <= x_d; y_q <= y_d; a_q <= a_d;
      dbank_q <= dbank_d; sbank_q <= sbank_d;
      fwd_q <= fwd_d; narrow_q <= narrow_d;
      data_q <= data_d; cyc_q <= cyc_d;
    end
  end

  assign rd_addr     = {sbank_q, x_q};
  assign wr_addr     = {dbank_q, y_q};
  assign wr_data     = data_q;
  assign x_out       = x_q;
  assign y_out       = y_q;
  assign a_out       = a_q;
  assign dbank_out   = dbank_q;
  assign cycle_units = cyc_q;

  // R2: destination bank taken from the first operand byte
  p_dbank_load_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && !busy) |=> dbank_out == $past(operand[BANK_W-1:0]));
  // R5: narrow mode keeps the high index byte across a byte step
  p_narrow_hi_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (step && narrow_q) |=> x_out[IDX_W-1:NARROW_W] == $past(x_out[IDX_W-1:NARROW_W]));
  // R6: completion leaves the count at all ones
  p_done_count_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> a_out == '1);
  // R7: each written byte costs the fixed number of units
  p_cost_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && wr_ack) |=> cycle_units == $past(cycle_units) + CYC_INC);
  // R8: one transfer at a time
  p_single_xfer_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rd_req && wr_req));
endmodule

// File: tb/test_blkmove_engine.sv
module test_blkmove_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, start, fwd, idx8, irq, rd_ack, wr_ack;
  logic [15:0] operand, x_in, y_in, a_in;
  logic rd_req, wr_req, busy, done, rewind;
  logic [23:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data, dbank_out;
  logic [15:0] x_out, y_out, a_out, cycle_units;

  int n_tests = 0, n_fail = 0, n_writes = 0, n_bad_data = 0, n_overlap = 0;
  logic [23:0] w_addr_log [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  blkmove_engine i_blkmove_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .fwd(fwd), .idx8(idx8),
    .operand(operand), .x_in(x_in), .y_in(y_in), .a_in(a_in), .irq(irq),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .x_out(x_out), .y_out(y_out), .a_out(a_out), .dbank_out(dbank_out),
    .cycle_units(cycle_units), .busy(busy), .done(done), .rewind(rewind)
  );

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[23:16] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign rd_data = mem_val(rd_addr);

  // memory responder: ack one cycle after a request; records writes
  logic [7:0] last_rd;
  initial begin
    rd_ack = 1'b0; wr_ack = 1'b0; last_rd = 8'h00;
    forever begin
      @(posedge clk);
      if (rd_req && wr_req) n_overlap++;
      if (rd_req && rd_ack) last_rd = rd_data;
      if (wr_req && wr_ack) begin
        if (n_writes < 64) w_addr_log[n_writes] = wr_addr;
        if (wr_data !== last_rd) n_bad_data++;
        n_writes++;
      end
      rd_ack <= rd_req && !rd_ack;
      wr_ack <= wr_req && !wr_ack;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected index after k steps
  function automatic logic [15:0] idx_after(input logic [15:0] v, input int k,
                                            input logic f, input logic n8);
    logic [15:0] r = v;
    for (int i = 0; i < k; i++) begin
      if (n8) r[7:0] = f ? r[7:0] + 8'd1 : r[7:0] - 8'd1;
      else    r      = f ? r + 16'd1 : r - 16'd1;
    end
    return r;
  endfunction

  // launch a move and wait for done or rewind; returns which ended it
  task automatic run_move(input logic [15:0] op, input logic [15:0] x, input logic [15:0] y,
                          input logic [15:0] a, input logic f, input logic n8,
                          output logic got_done, output logic got_rew);
    int waited = 0;
    @(negedge clk);
    operand = op; x_in = x; y_in = y; a_in = a; fwd = f; idx8 = n8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 1'b0; got_rew = 1'b0;
    while (!done && !rewind && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    got_done = done; got_rew = rewind;
    if (waited >= 5000) check("watchdog", 32'd1, 32'd0);
  endtask

  task automatic check_full(input string tag, input logic [15:0] op, input logic [15:0] x,
                            input logic [15:0] y, input logic [15:0] a,
                            input logic f, input logic n8, input int w0);
    int nb = int'(a) + 1;
    check({tag, " R9 done"}, 32'(done), 32'd1);
    check({tag, " R6 a_out"}, 32'(a_out), 32'hFFFF);
    check({tag, " R6 byte count"}, 32'(n_writes - w0), 32'(nb));
    check({tag, " R2 dbank"}, 32'(dbank_out), 32'(op[7:0]));
    check({tag, " R3/R4 x_out"}, 32'(x_out), 32'(idx_after(x, nb, f, n8)));
    check({tag, " R3/R4 y_out"}, 32'(y_out), 32'(idx_after(y, nb, f, n8)));
    for (int i = 0; i < nb && i < 8; i++)
      check({tag, " R2 write addr"}, 32'(w_addr_log[w0 + i]),
            32'({op[7:0], idx_after(y, i, f, n8)}));
    @(negedge clk);
    check({tag, " R9 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 rd_req", 32'(rd_req), 32'd0);
    check("R1 wr_req", 32'(wr_req), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 rewind", 32'(rewind), 32'd0);
  endtask

  task automatic t_forward;
    logic d, r;
    int w0 = n_writes;
    run_move(16'h3412, 16'h10F0, 16'h20F8, 16'd5, 1'b1, 1'b0, d, r);
    check("R7 cycle units fwd", 32'(cycle_units), 32'd12);
    check_full("R3 fwd", 16'h3412, 16'h10F0, 16'h20F8, 16'd5, 1'b1, 1'b0, w0);
  endtask

  task automatic t_backward;
    logic d, r;
    int w0 = n_writes;
    run_move(16'h0102, 16'h0002, 16'h8001, 16'd3, 1'b0, 1'b0, d, r);
    check("R7 cycle units bwd", 32'(cycle_units), 32'd8);
    check_full("R4 bwd", 16'h0102, 16'h0002, 16'h8001, 16'd3, 1'b0, 1'b0, w0);
  endtask

  task automatic t_narrow;
    logic d, r;
    int w0 = n_writes;
    run_move(16'h7F7E, 16'h12FE, 16'h3401, 16'd3, 1'b1, 1'b1, d, r);
    check("R5 x high kept", 32'(x_out[15:8]), 32'h12);
    check_full("R5 narrow fwd", 16'h7F7E, 16'h12FE, 16'h3401, 16'd3, 1'b1, 1'b1, w0);
    w0 = n_writes;
    run_move(16'h0505, 16'hAB01, 16'hCD00, 16'd2, 1'b0, 1'b1, d, r);
    check("R5 y high kept bwd", 32'(y_out[15:8]), 32'hCD);
    check_full("R5 narrow bwd", 16'h0505, 16'hAB01, 16'hCD00, 16'd2, 1'b0, 1'b1, w0);
  endtask

  task automatic t_single;
    logic d, r;
    int w0 = n_writes;
    run_move(16'h0908, 16'h4444, 16'h5555, 16'd0, 1'b1, 1'b0, d, r);
    check("R7 single cost", 32'(cycle_units), 32'd2);
    check_full("R6 single", 16'h0908, 16'h4444, 16'h5555, 16'd0, 1'b1, 1'b0, w0);
  endtask

  task automatic t_pause;
    logic d, r;
    int w0 = n_writes;
    irq = 1'b1;
    run_move(16'h2211, 16'h1000, 16'h2000, 16'd4, 1'b1, 1'b0, d, r);
    check("R10 rewind pulse", 32'(r), 32'd1);
    check("R10 no done", 32'(d), 32'd0);
    check("R10 idle", 32'(busy), 32'd0);
    check("R10 a held", 32'(a_out), 32'd3);
    check("R10 x held", 32'(x_out), 32'h1001);
    check("R10 y held", 32'(y_out), 32'h2001);
    check("R10 one byte", 32'(n_writes - w0), 32'd1);
    @(negedge clk);
    check("R10 rewind one cycle", 32'(rewind), 32'd0);
    irq = 1'b0;
    run_move(16'h2211, x_out, y_out, a_out, 1'b1, 1'b0, d, r);
    check_full("R10 resume", 16'h2211, 16'h1000, 16'h2000, 16'd4, 1'b1, 1'b0, w0);
  endtask

  task automatic t_lockout;
    logic d, r;
    int w0 = n_writes, waited = 0;
    @(negedge clk);
    operand = 16'h6655; x_in = 16'h0100; y_in = 16'h0200; a_in = 16'd3;
    fwd = 1'b1; idx8 = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    operand = 16'hEEDD; x_in = 16'h9999; y_in = 16'h8888; a_in = 16'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waited < 5000) begin @(negedge clk); waited++; end
    check("R11 stray start no bank change", 32'(dbank_out), 32'h55);
    operand = 16'h6655; x_in = 16'h0100; y_in = 16'h0200; a_in = 16'd3;
    check_full("R11 lockout", 16'h6655, 16'h0100, 16'h0200, 16'd3, 1'b1, 1'b0, w0);
    check("R11 still idle", 32'(busy), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; fwd = 1'b1; idx8 = 1'b0; irq = 1'b0;
    operand = '0; x_in = '0; y_in = '0; a_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_forward();
    t_backward();
    t_narrow();
    t_single();
    t_pause();
    t_lockout();
    check("R8 written byte equals byte read", 32'(n_bad_data), 32'd0);
    check("R8 no overlapping requests", 32'(n_overlap), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule